// File: doc/BRIEF.md
# Two-Counter Event Performance Monitor

This block counts hardware events on two programmable counters. Each cycle, a set of event lanes presents a hit strobe, an 8-bit event code and an 8-bit qualifier. Each counter has its own select register. The select register names the event code to match and a unit mask that filters the qualifiers. It can also apply a per-cycle threshold, an invert and an edge filter. It holds the counter's local enable and interrupt enable. A global control register gates both counters. A status register latches wraps past the 32-bit limit, and writes to an overflow-clear register release the latched bits. The interrupt line is the OR of the latched overflows whose interrupt enable is set.

Software reaches every register through one address and write strobe. Reads are combinational on the same address. The event lanes are plain per-cycle strobes that are sampled every clock edge. They are not a stream and have no back-pressure, because events can never be held off. To sample after a period of N events, software presets a counter to 2^32 - N, with N at most 2^31 - 1. Some event codes are wired only to counter 0.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: Counters sit at addresses 0x20 and 0x21, select registers at 0x28 and 0x29, status at 0x2d, overflow-clear at 0x2e and global control at 0x2f. Writing a counter loads its value. Overflow-clear and any unmapped address read zero. Global control and status read back in bits 1:0.
- R3: Counter i advances only while global control bit i is 1 and bit 22 of its select register is 1. Clearing global control halts counting and leaves the select registers unchanged.
- R4: A lane counts when its hit is 1, its code equals select bits 7:0, and either select bits 15:8 are zero or they share a set bit with the lane qualifier. With threshold bits 31:24 at zero, a counter adds the number of such lanes each cycle.
- R5: With a nonzero threshold, the counter adds 1 in a cycle where the matching-lane count is at least the threshold. When the invert bit 23 is set, it adds 1 when the count is below the threshold instead.
- R6: With a nonzero threshold and edge bit 18 set, the counter adds 1 only in a cycle where the threshold condition is true and was false in the cycle before.
- R7: The event codes 0xc3, 0xc4, 0xc8-0xcc, 0xce, 0xcf, 0xd7, 0xe3, 0xe6, 0xe7, 0xf1, 0xf2, 0xf6, 0xf7 and 0xfc-0xff never advance counter 1. They count normally on counter 0.
- R8: A counter is 32 bits and wraps modulo 2^32. When an increment carries past 0xFFFFFFFF, status bit i (0x2d) is set.
- R9: `irq` is high while some status bit i is set together with bit 20 of select register i.
- R10: Writing 1 to bit i of 0x2e clears status bit i. An overflow in the same cycle keeps the bit set.
- R11: A register write to a counter takes priority over events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| ev_hit | input | LANES | Per-lane event strobe |
| ev_code | input | 8*LANES | Per-lane event code, lane k at bits 8k+7:8k |
| ev_qual | input | 8*LANES | Per-lane qualifier, lane k at bits 8k+7:8k |
| irq | output | 1 | Overflow interrupt |

## Verification
Events presented before a rising edge show up in the counter read data just after that edge. The status bit sets at the same edge as the wrap, and `irq` follows the status and the select register with no extra delay. Register writes take effect at the edge that samples them. The edge filter compares the current cycle with the one before, so a sustained condition adds one count at its start. The bench changes every input on the falling clock edge. It reads each result at the following falling edge, one full rising edge later. For the invert case, it holds the lanes so that idle cycles add nothing.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int CODE_W = 8;

  localparam logic [ADDR_W-1:0] A_CNT0   = 8'h20;
  localparam logic [ADDR_W-1:0] A_SEL0   = 8'h28;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h2d;
  localparam logic [ADDR_W-1:0] A_OVFCLR = 8'h2e;
  localparam logic [ADDR_W-1:0] A_GCTRL  = 8'h2f;

  localparam int B_EDGE  = 18;
  localparam int B_INTEN = 20;
  localparam int B_EN    = 22;
  localparam int B_INV   = 23;

  // codes that only the first counter can observe
  function automatic logic first_ctr_only(input logic [CODE_W-1:0] code);
    return code inside {8'hc3, 8'hc4, [8'hc8:8'hcc], 8'hce, 8'hcf, 8'hd7,
                        8'he3, 8'he6, 8'he7, 8'hf1, 8'hf2, 8'hf6, 8'hf7,
                        [8'hfc:8'hff]};
  endfunction
endpackage

// File: rtl/pmu_event_filter.sv
module pmu_event_filter
  import pmu_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int INC_W    = $clog2(LANES + 1),
  parameter bit RESTRICT = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CODE_W-1:0]       want_code,
  input  logic [CODE_W-1:0]       umask,
  input  logic [CODE_W-1:0]       thresh,
  input  logic                    inv,
  input  logic                    edge_mode,
  input  logic [LANES-1:0]        ev_hit,
  input  logic [CODE_W*LANES-1:0] ev_code,
  input  logic [CODE_W*LANES-1:0] ev_qual,
  output logic [INC_W-1:0]        inc
);
  localparam int CMP_W = (INC_W > CODE_W ? INC_W : CODE_W) + 1;

  logic [INC_W-1:0] n_match;
  logic             cond, cond_q, blocked;
  logic [INC_W-1:0] raw;

  always_comb begin
    n_match = '0;
    for (int k = 0; k < LANES; k++) begin
      if (ev_hit[k] && ev_code[k*CODE_W +: CODE_W] == want_code &&
          (umask == '0 || (ev_qual[k*CODE_W +: CODE_W] & umask) != '0))
        n_match = n_match + INC_W'(1);
    end
  end

  always_comb begin
    if (inv) cond = CMP_W'(n_match) <  CMP_W'(thresh);
    else     cond = CMP_W'(n_match) >= CMP_W'(thresh);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;
  end

  always_comb begin
    if (thresh == '0)   raw = n_match;
    else if (edge_mode) raw = INC_W'(cond & ~cond_q);
    else                raw = INC_W'(cond);
  end

  generate
    if (RESTRICT) begin : g_restrict
      assign blocked = first_ctr_only(want_code);
    end else begin : g_open
      assign blocked = 1'b0;
    end
  endgenerate

  assign inc = blocked ? '0 : raw;

  // R5: thresholded modes add at most one per cycle
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh != '0) |-> (inc <= INC_W'(1)));

  // R6: edge mode never counts two cycles in a row
  a_r6_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    (thresh != '0 && edge_mode && inc != '0) |=> (!edge_mode || thresh == '0 || inc == '0 || !$stable(thresh)));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W     = 32,
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [INC_W-1:0] inc,
  input  logic             ld,
  input  logic [W-1:0]     ld_val,
  output logic [W-1:0]     cnt,
  output logic             wrap
);
  logic [W:0] sum;

  assign sum  = {1'b0, cnt} + (W+1)'(inc);
  assign wrap = run && !ld && sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (run) cnt <= sum[W-1:0];
  end

  // R8: a carry out of the top value lands at inc-1
  a_r8_wrap_value: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && run && !ld && inc != '0) |=> (cnt == W'($past(inc)) - W'(1)));

  // R11: a load beats any increment
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr_en,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic [LANES-1:0]        ev_hit,
  input  logic [CODE_W*LANES-1:0] ev_code,
  input  logic [CODE_W*LANES-1:0] ev_qual,
  output logic                    irq
);
  localparam int NCTR  = 2;
  localparam int INC_W = $clog2(LANES + 1);

  logic [REG_W-1:0] sel_q [NCTR];
  logic [REG_W-1:0] cnt   [NCTR];
  logic [INC_W-1:0] inc   [NCTR];
  logic [NCTR-1:0]  ld, run, wrap, inten;
  logic [NCTR-1:0]  gctrl_q, gstat_q, clr;

  generate
    for (genvar i = 0; i < NCTR; i++) begin : g_ctr
      localparam logic [ADDR_W-1:0] A_C = A_CNT0 + ADDR_W'(i);
      localparam logic [ADDR_W-1:0] A_S = A_SEL0 + ADDR_W'(i);

      assign ld[i]    = reg_wr_en && reg_addr == A_C;
      assign run[i]   = gctrl_q[i] && sel_q[i][B_EN];
      assign inten[i] = sel_q[i][B_INTEN];

      always_ff @(posedge clk) begin
        if (!rst_n)                          sel_q[i] <= '0;
        else if (reg_wr_en && reg_addr == A_S) sel_q[i] <= reg_wdata;
      end

      pmu_event_filter #(.LANES(LANES), .INC_W(INC_W), .RESTRICT(i == 1)) u_filt (
        .clk(clk), .rst_n(rst_n),
        .want_code(sel_q[i][7:0]), .umask(sel_q[i][15:8]), .thresh(sel_q[i][31:24]),
        .inv(sel_q[i][B_INV]), .edge_mode(sel_q[i][B_EDGE]),
        .ev_hit(ev_hit), .ev_code(ev_code), .ev_qual(ev_qual), .inc(inc[i]));

      pmu_counter #(.W(REG_W), .INC_W(INC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run[i]), .inc(inc[i]),
        .ld(ld[i]), .ld_val(reg_wdata), .cnt(cnt[i]), .wrap(wrap[i]));

      // R3: no gate, no load -> counter holds
      a_r3_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run[i] && !ld[i]) |=> $stable(cnt[i]));

      // R8: a wrap latches the status bit
      a_r8_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[i] |=> gstat_q[i]);

      // R10: a clear with no competing wrap drops the bit
      a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[i] && !wrap[i]) |=> !gstat_q[i]);
    end
  endgenerate

  assign clr = (reg_wr_en && reg_addr == A_OVFCLR) ? reg_wdata[NCTR-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gctrl_q <= '0;
      gstat_q <= '0;
    end else begin
      if (reg_wr_en && reg_addr == A_GCTRL) gctrl_q <= reg_wdata[NCTR-1:0];
      gstat_q <= (gstat_q & ~clr) | wrap;
    end
  end

  assign irq = |(gstat_q & inten);

  always_comb begin
    unique case (reg_addr)
      A_CNT0:              reg_rdata = cnt[0];
      A_CNT0 + 8'd1:       reg_rdata = cnt[1];
      A_SEL0:              reg_rdata = sel_q[0];
      A_SEL0 + 8'd1:       reg_rdata = sel_q[1];
      A_STATUS:            reg_rdata = REG_W'(gstat_q);
      A_GCTRL:             reg_rdata = REG_W'(gctrl_q);
      default:             reg_rdata = '0;
    endcase
  end

  // R7: restricted code keeps counter 1 frozen
  a_r7_ctr1_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (first_ctr_only(sel_q[1][7:0]) && !ld[1]) |=> $stable(cnt[1]));

  // R9: interrupt only with a latched, enabled overflow
  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (gstat_q != '0));
endmodule

// File: tb/perf_mon_unit_test.sv
module perf_mon_unit_test;
  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [LANES-1:0]   ev_hit;
  logic [8*LANES-1:0] ev_code;
  logic [8*LANES-1:0] ev_qual;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  perf_mon_unit #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_hit(ev_hit),
    .ev_code(ev_code), .ev_qual(ev_qual), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // drive all lanes with one code and qualifier for one cycle
  task automatic evt(input logic [LANES-1:0] hit, input logic [7:0] code, input logic [7:0] qual);
    @(negedge clk);
    ev_hit = hit;
    ev_code = {LANES{code}};
    ev_qual = {LANES{qual}};
    @(negedge clk);
    ev_hit = '0;
  endtask

  task automatic prep(input logic [31:0] s0, input logic [31:0] s1, input logic [1:0] g);
    wr(8'h2f, 32'h0);
    wr(8'h28, s0); wr(8'h29, s1);
    wr(8'h20, 32'h0); wr(8'h21, 32'h0);
    wr(8'h2f, {30'h0, g});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (uut.sel_q[k]) ;
    rd(8'h20, v); chk("R1 cnt0", v, 0);
    rd(8'h21, v); chk("R1 cnt1", v, 0);
    rd(8'h28, v); chk("R1 sel0", v, 0);
    rd(8'h2d, v); chk("R1 status", v, 0);
    rd(8'h2f, v); chk("R1 gctrl", v, 0);
    chk("R1 irq", {31'h0, irq}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(8'h29, 32'h1234_5678); rd(8'h29, v); chk("R2 sel1 readback", v, 32'h1234_5678);
    wr(8'h21, 32'hCAFE_0001); rd(8'h21, v); chk("R2 cnt1 load", v, 32'hCAFE_0001);
    wr(8'h2f, 32'hFFFF_FFFF); rd(8'h2f, v); chk("R2 gctrl width", v, 32'h3);
    rd(8'h2e, v); chk("R2 ovfclr reads zero", v, 0);
    rd(8'h30, v); chk("R2 unmapped", v, 0);
    wr(8'h2f, 32'h0); wr(8'h29, 32'h0); wr(8'h21, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] v;
    prep(32'h0040_0012, 32'h0, 2'b00);
    evt(4'b0001, 8'h12, 8'h00);
    rd(8'h20, v); chk("R3 global off holds", v, 0);
    wr(8'h2f, 32'h1);
    evt(4'b0001, 8'h12, 8'h00);
    rd(8'h20, v); chk("R3 both enables count", v, 1);
    wr(8'h28, 32'h0000_0012);
    evt(4'b0001, 8'h12, 8'h00);
    rd(8'h20, v); chk("R3 local off holds", v, 1);
    wr(8'h2f, 32'h0);
    rd(8'h28, v); chk("R3 select kept", v, 32'h0000_0012);
  endtask

  task automatic t_lanes;
    logic [31:0] v;
    prep(32'h0040_0012, 32'h0, 2'b01);
    evt(4'b1111, 8'h12, 8'h00);
    rd(8'h20, v); chk("R4 four lanes", v, 4);
    @(negedge clk);
    ev_hit = 4'b1111; ev_code = {8'h12, 8'h33, 8'h12, 8'h44}; ev_qual = '0;
    @(negedge clk); ev_hit = '0;
    rd(8'h20, v); chk("R4 code match only", v, 6);
    wr(8'h28, 32'h0040_0112);
    @(negedge clk);
    ev_hit = 4'b0111; ev_code = {4{8'h12}}; ev_qual = {8'h01, 8'h03, 8'h02, 8'h01};
    @(negedge clk); ev_hit = '0;
    rd(8'h20, v); chk("R4 unit mask", v, 8);
  endtask

  task automatic t_thresh;
    logic [31:0] v, base;
    prep(32'h0240_0012, 32'h0, 2'b01);
    evt(4'b0111, 8'h12, 8'h00);
    rd(8'h20, v); chk("R5 at threshold", v, 1);
    evt(4'b0001, 8'h12, 8'h00);
    rd(8'h20, v); chk("R5 below threshold", v, 1);
    // invert: hold three lanes so idle cycles never count
    wr(8'h2f, 32'h0);
    @(negedge clk); ev_hit = 4'b0111; ev_code = {4{8'h12}}; ev_qual = '0;
    wr(8'h28, 32'h02C0_0012);
    wr(8'h2f, 32'h1);
    rd(8'h20, base);
    @(negedge clk); @(negedge clk);
    rd(8'h20, v); chk("R5 invert idle", v, base);
    @(negedge clk); ev_hit = 4'b0001;
    @(negedge clk); ev_hit = 4'b0111;
    rd(8'h20, v); chk("R5 invert below", v, base + 1);
    wr(8'h2f, 32'h0);
    @(negedge clk); ev_hit = '0;
  endtask

  task automatic t_edge;
    logic [31:0] v;
    prep(32'h0144_0012, 32'h0, 2'b01);
    @(negedge clk); ev_hit = 4'b0001; ev_code = {4{8'h12}}; ev_qual = '0;
    repeat (3) @(negedge clk);
    ev_hit = '0;
    rd(8'h20, v); chk("R6 held condition once", v, 1);
    evt(4'b0010, 8'h12, 8'h00);
    rd(8'h20, v); chk("R6 new rising edge", v, 2);
  endtask

  task automatic t_restrict;
    logic [31:0] v;
    prep(32'h0040_00CB, 32'h0040_00CB, 2'b11);
    evt(4'b0011, 8'hCB, 8'h00);
    rd(8'h20, v); chk("R7 ctr0 counts restricted", v, 2);
    rd(8'h21, v); chk("R7 ctr1 blocked", v, 0);
    wr(8'h29, 32'h0040_00CD);
    evt(4'b0001, 8'hCD, 8'h00);
    rd(8'h21, v); chk("R7 ctr1 open code", v, 1);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    prep(32'h0040_0012, 32'h0, 2'b01);
    wr(8'h20, 32'hFFFF_FFFE);
    evt(4'b0111, 8'h12, 8'h00);
    rd(8'h20, v); chk("R8 wrap value", v, 1);
    rd(8'h2d, v); chk("R8 status set", v, 1);
    chk("R9 irq needs enable", {31'h0, irq}, 0);
    wr(8'h28, 32'h0050_0012);
    chk("R9 irq raised", {31'h0, irq}, 1);
    wr(8'h2e, 32'h1);
    rd(8'h2d, v); chk("R10 status cleared", v, 0);
    chk("R10 irq dropped", {31'h0, irq}, 0);
    wr(8'h20, 32'hFFFF_FFFF);
    @(negedge clk);
    ev_hit = 4'b0001; ev_code = {4{8'h12}}; ev_qual = '0;
    reg_wr_en = 1'b1; reg_addr = 8'h2e; reg_wdata = 32'h1;
    @(negedge clk); ev_hit = '0; reg_wr_en = 1'b0;
    rd(8'h2d, v); chk("R10 wrap beats clear", v, 1);
    wr(8'h2e, 32'h1);
  endtask

  task automatic t_load;
    logic [31:0] v;
    prep(32'h0040_0012, 32'h0, 2'b01);
    @(negedge clk);
    ev_hit = 4'b1111; ev_code = {4{8'h12}}; ev_qual = '0;
    reg_wr_en = 1'b1; reg_addr = 8'h20; reg_wdata = 32'd5;
    @(negedge clk); ev_hit = '0; reg_wr_en = 1'b0;
    rd(8'h20, v); chk("R11 write wins", v, 5);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    ev_hit = '0; ev_code = '0; ev_qual = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_gate();
    t_lanes();
    t_thresh();
    t_edge();
    t_restrict();
    t_overflow();
    t_load();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule